// File: doc/BRIEF.md
# Interrupt Pending Vector Register

This block records frame-completion events from a group of DMA channels and presents them through one read-only register. Each channel raises a one-cycle completion pulse; the block latches it in a per-channel pending flag. A separate per-channel enable mask decides which flags may be reported and which may raise the group interrupt line.

A read strobe returns the highest-priority enabled pending channel as an encoded number. Zero means that nothing is pending. Any other value is the channel index plus one. In the same clock the read clears the flag of the channel it reported. Software services the group by reading until it gets zero. Each other interrupt group or type is a separate instance.

Top module: `ipv_vector_reg`

## Requirements
- R1: A one-cycle pulse on `evt_i[k]` sets the pending flag of channel k (k from 0 to 15) at the next clock edge, and the flag stays set until a read reports channel k.
- R2: A read when no enabled channel has its flag set returns 0 in bits 5:0.
- R3: A read returns, in bits 5:0, the index plus one of the lowest-numbered channel whose flag and enable are both set. Channel 0 reads as 1 and channel 15 reads as 16.
- R4: A read clears only the flag of the channel it reported. All other flags keep their value.
- R5: When a completion pulse for the reported channel arrives in the same cycle as the read, that channel's flag stays set.
- R6: Bits 31:6 of `rdata_o` always read 0, and bits 5:0 never hold a value from 17 to 63.
- R7: `irq_o` is high exactly when at least one channel has both its flag and its enable set. It follows the enables in the same cycle.
- R8: A channel whose enable is low still latches its flag, but it is left out of the read result and out of `irq_o`. Once it is enabled, it is reported.
- R9: While `rst_ni` is low, all flags are cleared, `rdata_o` is 0 and `irq_o` is low.
- R10: `rdata_o` changes only on the clock edge that samples `rd_i` high, and it shows the result from the next cycle on. Without a read it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Per-channel completion pulses |
| en_i | input | 16 | Per-channel interrupt enables |
| rd_i | input | 1 | Register read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Group interrupt, any enabled flag pending |

## Verification
A lost or stuck pending flag first shows on `irq_o` in the same cycle, because `irq_o` follows the flags and the enables directly. It then shows as a wrong or missing code in `rdata_o` one cycle after the next read strobe. A wrong priority or a wrong clear shows up only when reads are repeated, so the bench drains the group with back-to-back reads and compares every cycle against a behavioural model. Races between an event and a read, and flags latched while their channel is disabled, are set up on purpose, because an error there stays hidden until the channel is enabled or read again.

// File: rtl/ipv_pkg.sv
package ipv_pkg;
  localparam int unsigned CH_MAX = 16;
  typedef enum logic [0:0] {
    RD_IDLE = 1'b0,
    RD_TAKE = 1'b1
  } rd_op_e;
endpackage

// File: rtl/ipv_pending_bank.sv
module ipv_pending_bank #(
  parameter int unsigned N_CH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] set_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] pend_o
);
  logic [N_CH-1:0] pend_q;

  for (genvar i = 0; i < N_CH; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= 1'b0;
      else if (set_i[i]) pend_q[i] <= 1'b1;  // new event beats clear
      else if (clr_i[i]) pend_q[i] <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ipv_prio_enc.sv
module ipv_prio_enc #(
  parameter int unsigned N_CH    = 16,
  parameter int unsigned FIELD_W = 6
) (
  input  logic [N_CH-1:0]    req_i,
  output logic [N_CH-1:0]    grant_o,
  output logic [FIELD_W-1:0] code_o,
  output logic               any_o
);
  logic [N_CH:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_CH; i++) begin : g_chain
    assign grant_o[i] = req_i[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | req_i[i];
  end
  assign any_o = seen[N_CH];

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (grant_o[i]) code_o = code_o | FIELD_W'(i + 1);
    end
  end
endmodule

// File: rtl/ipv_read_port.sv
module ipv_read_port #(
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  ipv_pkg::rd_op_e       op_i,
  input  logic [FIELD_W-1:0]    code_i,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int unsigned PAD_W = DATA_W - FIELD_W;
  logic [FIELD_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else if (op_i == ipv_pkg::RD_TAKE) code_q <= code_i;
  end

  assign rdata_o = {{PAD_W{1'b0}}, code_q};
endmodule

// File: rtl/ipv_vector_reg.sv
module ipv_vector_reg #(
  parameter int unsigned N_CH    = ipv_pkg::CH_MAX,
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   evt_i,
  input  logic [N_CH-1:0]   en_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_CH-1:0]    pend;
  logic [N_CH-1:0]    req;
  logic [N_CH-1:0]    grant;
  logic [N_CH-1:0]    clr;
  logic [FIELD_W-1:0] code;
  logic               any_req;
  ipv_pkg::rd_op_e    op;

  assign req = pend & en_i;
  assign op  = rd_i ? ipv_pkg::RD_TAKE : ipv_pkg::RD_IDLE;
  assign clr = (op == ipv_pkg::RD_TAKE) ? grant : '0;

  ipv_pending_bank #(.N_CH(N_CH)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_i),
    .clr_i (clr),
    .pend_o(pend)
  );

  ipv_prio_enc #(.N_CH(N_CH), .FIELD_W(FIELD_W)) u_enc (
    .req_i  (req),
    .grant_o(grant),
    .code_o (code),
    .any_o  (any_req)
  );

  ipv_read_port #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_port (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .code_i (code),
    .rdata_o(rdata_o)
  );

  assign irq_o = any_req;
endmodule

// File: rtl/ipv_vector_reg_chk.sv
module ipv_vector_reg_chk #(
  parameter int unsigned N_CH    = 16,
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned DATA_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CH-1:0]   evt_i,
  input logic [N_CH-1:0]   en_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [N_CH-1:0]   pend
);
  // R6
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:FIELD_W] == '0);
  // R6
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[FIELD_W-1:0] <= FIELD_W'(N_CH));
  // R2
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !irq_o |=> rdata_o == '0);
  // R3
  busy_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && irq_o |=> rdata_o != '0);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  // R7
  irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((pend & en_i) != '0));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    // R1
    set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> pend[i]);
    // R4
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_i && irq_o && rdata_o != FIELD_W'(i + 1) && pend[i] |=> pend[i] || rdata_o == DATA_W'(i + 1));
  end
endmodule

bind ipv_vector_reg ipv_vector_reg_chk #(.N_CH(N_CH), .FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .evt_i  (evt_i),
  .en_i   (en_i),
  .rd_i   (rd_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .pend   (pend)
);

// File: tb/ipv_vector_reg_test.sv
module ipv_vector_reg_test;
  localparam int N = 16;
  localparam logic [15:0] ALL = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] evt_i = '0;
  logic [15:0] en_i = '0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  logic [15:0] m_pend = '0;
  int          m_rdata = 0;

  always #10 clk = ~clk;

  ipv_vector_reg uut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .en_i(en_i),
    .rd_i(rd_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    check("R3 model rdata", rdata_o, m_rdata);
    check("R7 model irq", irq_o, ((m_pend & en_i) != 0));
    check("R6 upper bits", rdata_o[31:6], 0);
  endtask

  task automatic model_edge();
    if (rd_i) begin
      m_rdata = 0;
      for (int i = 0; i < N; i++) begin
        if (m_rdata == 0 && m_pend[i] && en_i[i]) begin
          m_rdata = i + 1;
          m_pend[i] = 1'b0;
        end
      end
    end
    m_pend = m_pend | evt_i;
  endtask

  task automatic step(input logic [15:0] ev, input logic [15:0] en, input logic rd);
    @(negedge clk);
    compare();
    evt_i = ev; en_i = en; rd_i = rd;
    @(posedge clk);
    model_edge();
  endtask

  task automatic chk_rd(input string tag, input int exp);
    #2 check(tag, rdata_o, exp);
  endtask

  task automatic chk_irq(input string tag, input int exp);
    #2 check(tag, irq_o, exp);
  endtask

  initial begin
    #(20ns * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    evt_i = ALL;
    @(negedge clk);
    check("R9 reset rdata", rdata_o, 0);
    check("R9 reset irq", irq_o, 0);
    evt_i = '0; en_i = ALL;
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9 flags clear after reset", irq_o, 0);

    // R3 priority, R2 empty
    step(16'h0024, ALL, 1'b0);
    step(16'h0000, ALL, 1'b1); chk_rd("R3 lowest first", 3); chk_irq("R7 one left", 1);
    step(16'h0000, ALL, 1'b1); chk_rd("R3 second", 6);
    step(16'h0000, ALL, 1'b1); chk_rd("R2 empty read", 0); chk_irq("R7 drained", 0);

    // R8 masked channel latches
    step(16'h0200, ~16'h0200, 1'b0);
    step(16'h0000, ~16'h0200, 1'b0); chk_irq("R8 masked irq", 0);
    step(16'h0000, ~16'h0200, 1'b1); chk_rd("R8 masked read", 0);
    step(16'h0000, ALL, 1'b1); chk_rd("R8 enabled later", 10);

    // R5 race, channel 15 boundary
    step(16'h8000, ALL, 1'b0);
    step(16'h8000, ALL, 1'b1); chk_rd("R3 channel 15", 16);
    step(16'h0000, ALL, 1'b1); chk_rd("R5 event wins", 16);
    step(16'h0000, ALL, 1'b1); chk_rd("R5 then empty", 0);

    // R10 hold, channel 0
    step(16'h0001, ALL, 1'b0); chk_rd("R10 holds without read", 0);
    step(16'h0000, ALL, 1'b1); chk_rd("R1 channel 0", 1);
    step(16'h0000, ALL, 1'b0); chk_rd("R10 holds after read", 1);

    // R4 only reported flag cleared
    step(16'h0018, ALL, 1'b0);
    step(16'h0000, ALL, 1'b1); chk_rd("R4 first", 4);
    step(16'h0000, ALL, 1'b1); chk_rd("R4 other untouched", 5);

    for (int c = 0; c < 4000; c++) begin
      logic [15:0] ev;
      logic [15:0] en;
      ev = 16'($urandom) & 16'($urandom) & 16'($urandom);
      en = 16'($urandom) | 16'($urandom);
      step(ev, en, 1'($urandom));
    end
    @(negedge clk);
    compare();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule